// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block fetches and executes a small set of 8-bit opcodes from a synchronous byte-wide memory, one byte per cycle. Each instruction is one opcode byte, or an opcode byte followed by a two-byte big-endian operand. The block keeps a 16-bit program counter, a 16-bit index register and a 16-bit stack pointer. The stack grows downward, and a subroutine call writes its return address to the stack through the same memory port.

The memory port has these rules. The address is driven combinationally from the sequencer state. Read data is taken in the cycle after its address was presented. A write happens on any clock edge where the write strobe is high. The architectural registers and two flags are brought out as ports so that a surrounding system can observe execution. The asynchronous active-low reset is released through a two-stage synchroniser, so execution begins on the third clock edge after release.

Top module: `vlen_fetch_seq`

## Requirements
- R1: While reset is held, and for the first two edges after its release, the block shows PC = START_ADDR (default 0xC000), X = 0, SP = 0, done = 0, illegal = 0, write strobe low and address = START_ADDR.
- R2: Each instruction begins with a fetch cycle whose address is the current PC. The PC advances by one for every instruction byte, so the next fetch is at the old PC + 1 for one-byte opcodes and at the old PC + 3 for three-byte opcodes.
- R3: Opcode 0x08 is one byte long and adds one to X, wrapping from 0xFFFF to 0x0000. It takes two cycles.
- R4: Opcode 0xCE is three bytes long and loads X with the operand, where the first operand byte is the high half. It takes four cycles.
- R5: Opcode 0xFE is three bytes long. It reads memory at the operand address E and then at E+1 (wrapping modulo 2^16), and loads X with {byte at E, byte at E+1}. It takes seven cycles.
- R6: Opcode 0x8E is three bytes long and loads SP with the big-endian operand. It takes four cycles.
- R7: Opcode 0xBD is three bytes long and takes six cycles. The return address is the byte after the instruction. Its low byte is written at SP, then its high byte at SP-1. SP ends two lower, and the next fetch is at the operand address.
- R8: Opcode 0x3F halts the block. From the cycle after its decode, done stays high, the PC stays frozen at the byte after the opcode, and no further writes occur.
- R9: Any other opcode is a one-byte no-operation that leaves X and SP unchanged and sets an illegal flag. The flag stays set until reset.
- R10: Read data is used in the cycle after its address. The write strobe is high only during the two push cycles of a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address for read or write |
| mem_rdata | input | 8 | Read data, one cycle after its address |
| mem_we | output | 1 | Write strobe for stack pushes |
| mem_wdata | output | 8 | Write data |
| pc_o | output | 16 | Program counter |
| x_o | output | 16 | Index register |
| sp_o | output | 16 | Stack pointer |
| done_o | output | 1 | Halt indication |
| illegal_o | output | 1 | Sticky unknown-opcode flag |

## Verification
Two pairs of functions can fall in the same cycle. First, the decode of an opcode happens in the same cycle as the fetch of the following byte, so a one-byte opcode issues a read of the next address before its own outcome is known. Second, the call's second stack write happens in the same edge as the program counter jump, and the stack pointer can wrap through zero exactly while a return address is being written. The program provokes both: it places single-byte opcodes between operand-carrying ones, sets SP to zero before a call, and then reads the pushed bytes back through the indirect load across the 0xFFFF/0x0000 boundary. A behavioural model compares address, strobe, data and all registers on every clock, including across a reset that lands in the middle of an instruction.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  localparam logic [7:0] OPC_INCX = 8'h08;
  localparam logic [7:0] OPC_LDXI = 8'hCE;
  localparam logic [7:0] OPC_LDXM = 8'hFE;
  localparam logic [7:0] OPC_LDSI = 8'h8E;
  localparam logic [7:0] OPC_CALL = 8'hBD;
  localparam logic [7:0] OPC_STOP = 8'h3F;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_OPC,
    ST_OPHI,
    ST_OPLO,
    ST_MRDH,
    ST_MRDL,
    ST_MFIN,
    ST_PSHL,
    ST_PSHH,
    ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    K_INCX,
    K_LDXI,
    K_LDXM,
    K_LDSI,
    K_CALL,
    K_STOP,
    K_BAD
  } op_kind_e;

endpackage

// File: rtl/vlen_decode.sv
module vlen_decode
  import vlen_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind
);

  always_comb begin
    case (opcode)
      OPC_INCX: kind = K_INCX;
      OPC_LDXI: kind = K_LDXI;
      OPC_LDXM: kind = K_LDXM;
      OPC_LDSI: kind = K_LDSI;
      OPC_CALL: kind = K_CALL;
      OPC_STOP: kind = K_STOP;
      default:  kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_kind_e   kind_in,
  output seq_state_e state,
  output logic       pc_inc,
  output logic       pc_ld_ea,
  output logic       x_inc,
  output logic       x_ld_opnd,
  output logic       x_ld_mem,
  output logic       sp_ld_opnd,
  output logic       sp_dec,
  output logic       hi_cap,
  output logic       ea_cap,
  output logic       mhi_cap,
  output logic       done,
  output logic       illegal
);

  seq_state_e state_q, state_d;
  op_kind_e   kind_q, kind_d;
  logic       kind_en;
  logic       done_q, done_set;
  logic       ill_q, ill_set;

  // next-state and strobe decode
  always_comb begin
    state_d    = state_q;
    kind_en    = 1'b0;
    pc_inc     = 1'b0;
    pc_ld_ea   = 1'b0;
    x_inc      = 1'b0;
    x_ld_opnd  = 1'b0;
    x_ld_mem   = 1'b0;
    sp_ld_opnd = 1'b0;
    sp_dec     = 1'b0;
    hi_cap     = 1'b0;
    ea_cap     = 1'b0;
    mhi_cap    = 1'b0;
    done_set   = 1'b0;
    ill_set    = 1'b0;
    case (state_q)
      ST_FETCH: begin
        pc_inc  = 1'b1;
        state_d = ST_OPC;
      end
      ST_OPC: begin
        kind_en = 1'b1;
        case (kind_in)
          K_INCX: begin
            x_inc   = 1'b1;
            state_d = ST_FETCH;
          end
          K_STOP: begin
            done_set = 1'b1;
            state_d  = ST_HALT;
          end
          K_BAD: begin
            ill_set = 1'b1;
            state_d = ST_FETCH;
          end
          default: begin
            pc_inc  = 1'b1;
            state_d = ST_OPHI;
          end
        endcase
      end
      ST_OPHI: begin
        hi_cap  = 1'b1;
        pc_inc  = 1'b1;
        state_d = ST_OPLO;
      end
      ST_OPLO: begin
        case (kind_q)
          K_LDXI: begin
            x_ld_opnd = 1'b1;
            state_d   = ST_FETCH;
          end
          K_LDSI: begin
            sp_ld_opnd = 1'b1;
            state_d    = ST_FETCH;
          end
          K_LDXM: begin
            ea_cap  = 1'b1;
            state_d = ST_MRDH;
          end
          K_CALL: begin
            ea_cap  = 1'b1;
            state_d = ST_PSHL;
          end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_MRDH: state_d = ST_MRDL;
      ST_MRDL: begin
        mhi_cap = 1'b1;
        state_d = ST_MFIN;
      end
      ST_MFIN: begin
        x_ld_mem = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_PSHL: begin
        sp_dec  = 1'b1;
        state_d = ST_PSHH;
      end
      ST_PSHH: begin
        sp_dec   = 1'b1;
        pc_ld_ea = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  assign kind_d = kind_en ? kind_in : kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      kind_q  <= K_INCX;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      if (done_set) done_q <= 1'b1;
      if (ill_set)  ill_q  <= 1'b1;
    end
  end

  assign state   = state_q;
  assign done    = done_q;
  assign illegal = ill_q;

endmodule

// File: rtl/vlen_datapath.sv
module vlen_datapath #(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rdata,
  input  logic              pc_inc,
  input  logic              pc_ld_ea,
  input  logic              x_inc,
  input  logic              x_ld_opnd,
  input  logic              x_ld_mem,
  input  logic              sp_ld_opnd,
  input  logic              sp_dec,
  input  logic              hi_cap,
  input  logic              ea_cap,
  input  logic              mhi_cap,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] x,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] ea
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d, x_q, x_d, sp_q, sp_d, ea_q, ea_d;
  logic [DATA_W-1:0] hi_q, hi_d, mhi_q, mhi_d;
  logic [ADDR_W-1:0] opnd;
  logic              pc_en, x_en, sp_en;

  assign opnd = {hi_q, rdata};

  always_comb begin
    pc_en = pc_inc | pc_ld_ea;
    pc_d  = pc_ld_ea ? ea_q : pc_q + ONE;

    x_en = x_inc | x_ld_opnd | x_ld_mem;
    if (x_ld_opnd)     x_d = opnd;
    else if (x_ld_mem) x_d = {mhi_q, rdata};
    else               x_d = x_q + ONE;

    sp_en = sp_ld_opnd | sp_dec;
    sp_d  = sp_ld_opnd ? opnd : sp_q - ONE;

    ea_d  = opnd;
    hi_d  = rdata;
    mhi_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= START_ADDR;
      x_q   <= '0;
      sp_q  <= '0;
      ea_q  <= '0;
      hi_q  <= '0;
      mhi_q <= '0;
    end else begin
      if (pc_en)   pc_q  <= pc_d;
      if (x_en)    x_q   <= x_d;
      if (sp_en)   sp_q  <= sp_d;
      if (ea_cap)  ea_q  <= ea_d;
      if (hi_cap)  hi_q  <= hi_d;
      if (mhi_cap) mhi_q <= mhi_d;
    end
  end

  assign pc = pc_q;
  assign x  = x_q;
  assign sp = sp_q;
  assign ea = ea_q;

endmodule

// File: rtl/vlen_fetch_seq.sv
module vlen_fetch_seq
  import vlen_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [15:0] START_ADDR = 16'hC000,
  parameter int          RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic [15:0] pc_o,
  output logic [15:0] x_o,
  output logic [15:0] sp_o,
  output logic        done_o,
  output logic        illegal_o
);

  localparam int ADDR_W = 2 * DATA_W;

  logic rst_int_n;

  generate
    if (RST_STAGES <= 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_int_n = sync_q;
    end else begin : g_syncn
      logic [RST_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[RST_STAGES-2:0], 1'b1};
      end
      assign rst_int_n = sync_q[RST_STAGES-1];
    end
  endgenerate

  op_kind_e          kind;
  seq_state_e        state;
  logic              pc_inc, pc_ld_ea, x_inc, x_ld_opnd, x_ld_mem;
  logic              sp_ld_opnd, sp_dec, hi_cap, ea_cap, mhi_cap;
  logic [ADDR_W-1:0] pc, x, sp, ea;

  vlen_decode u_dec (
    .opcode (mem_rdata),
    .kind   (kind)
  );

  vlen_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .kind_in    (kind),
    .state      (state),
    .pc_inc     (pc_inc),
    .pc_ld_ea   (pc_ld_ea),
    .x_inc      (x_inc),
    .x_ld_opnd  (x_ld_opnd),
    .x_ld_mem   (x_ld_mem),
    .sp_ld_opnd (sp_ld_opnd),
    .sp_dec     (sp_dec),
    .hi_cap     (hi_cap),
    .ea_cap     (ea_cap),
    .mhi_cap    (mhi_cap),
    .done       (done_o),
    .illegal    (illegal_o)
  );

  vlen_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rdata      (mem_rdata),
    .pc_inc     (pc_inc),
    .pc_ld_ea   (pc_ld_ea),
    .x_inc      (x_inc),
    .x_ld_opnd  (x_ld_opnd),
    .x_ld_mem   (x_ld_mem),
    .sp_ld_opnd (sp_ld_opnd),
    .sp_dec     (sp_dec),
    .hi_cap     (hi_cap),
    .ea_cap     (ea_cap),
    .mhi_cap    (mhi_cap),
    .pc         (pc),
    .x          (x),
    .sp         (sp),
    .ea         (ea)
  );

  // memory port steering
  always_comb begin
    case (state)
      ST_MRDH:          mem_addr = ea;
      ST_MRDL:          mem_addr = ea + ADDR_W'(1);
      ST_PSHL, ST_PSHH: mem_addr = sp;
      default:          mem_addr = pc;
    endcase
    mem_we    = (state == ST_PSHL) || (state == ST_PSHH);
    mem_wdata = (state == ST_PSHH) ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];
  end

  assign pc_o = pc;
  assign x_o  = x;
  assign sp_o = sp;

endmodule

// File: rtl/vlen_fetch_seq_chk.sv
module vlen_fetch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic        done,
  input logic        illegal
);

  // R8
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(pc) && !mem_we));

  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R7
  push_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_wdata == pc[7:0] && mem_addr == sp));

  // R7
  push_high_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_wdata == pc[15:8] &&
                                   mem_addr == $past(mem_addr) - 16'd1));

  // R10
  push_pair_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |=> !mem_we);

  // R7
  sp_two_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we) |-> (sp == $past(sp, 2) - 16'd2));

endmodule

bind vlen_fetch_seq vlen_fetch_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc        (pc_o),
  .sp        (sp_o),
  .done      (done_o),
  .illegal   (illegal_o)
);

// File: tb/test_vlen_fetch_seq.sv
module test_vlen_fetch_seq;

  localparam logic [15:0] START = 16'hC000;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [15:0] pc_o, x_o, sp_o;
  logic        done_o, illegal_o;

  int n_cmp = 0;
  int n_bad = 0;

  vlen_fetch_seq #(.START_ADDR(START)) i_vlen_fetch_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pc_o      (pc_o),
    .x_o       (x_o),
    .sp_o      (sp_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // environment memory
  logic [7:0] env_mem [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] env_rd(input logic [15:0] a);
    return env_mem.exists(int'(a)) ? env_mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_we) env_mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= env_rd(mem_addr);
  end

  // reference model
  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    logic [15:0] pc, x, sp;
    logic        done, ill;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] m_pc, m_x, m_sp;
  logic        m_ill, m_halt;
  int          rel;

  function automatic exp_t mk(input logic [15:0] addr, input logic we,
                              input logic [7:0] wd, input logic [15:0] pc,
                              input logic [15:0] sp, input logic dn,
                              input string tag);
    exp_t e;
    e.addr = addr; e.we = we; e.wd = wd; e.pc = pc;
    e.x = m_x; e.sp = sp; e.done = dn; e.ill = m_ill; e.tag = tag;
    return e;
  endfunction

  task automatic step();
    logic [15:0] a, a1, a2, a3, opnd, ea, ea1;
    logic [7:0]  op;
    string       t;
    if (m_halt) begin
      q.push_back(mk(m_pc, 1'b0, 8'h00, m_pc, m_sp, 1'b1, "R8"));
      return;
    end
    a  = m_pc;
    a1 = a + 16'd1;
    a2 = a + 16'd2;
    a3 = a + 16'd3;
    op = ref_rd(a);
    q.push_back(mk(a, 1'b0, 8'h00, a, m_sp, 1'b0, "R2"));
    case (op)
      8'h08: begin
        q.push_back(mk(a1, 1'b0, 8'h00, a1, m_sp, 1'b0, "R3"));
        m_x  = m_x + 16'd1;
        m_pc = a1;
      end
      8'h3F: begin
        q.push_back(mk(a1, 1'b0, 8'h00, a1, m_sp, 1'b0, "R8"));
        m_halt = 1'b1;
        m_pc   = a1;
      end
      8'hCE, 8'hFE, 8'h8E, 8'hBD: begin
        t = (op == 8'hCE) ? "R4" : (op == 8'hFE) ? "R5" :
            (op == 8'h8E) ? "R6" : "R7";
        q.push_back(mk(a1, 1'b0, 8'h00, a1, m_sp, 1'b0, t));
        q.push_back(mk(a2, 1'b0, 8'h00, a2, m_sp, 1'b0, t));
        q.push_back(mk(a3, 1'b0, 8'h00, a3, m_sp, 1'b0, t));
        opnd = {ref_rd(a1), ref_rd(a2)};
        m_pc = a3;
        if (op == 8'hCE) m_x = opnd;
        else if (op == 8'h8E) m_sp = opnd;
        else if (op == 8'hFE) begin
          ea  = opnd;
          ea1 = ea + 16'd1;
          q.push_back(mk(ea, 1'b0, 8'h00, a3, m_sp, 1'b0, "R5"));
          q.push_back(mk(ea1, 1'b0, 8'h00, a3, m_sp, 1'b0, "R5"));
          q.push_back(mk(a3, 1'b0, 8'h00, a3, m_sp, 1'b0, "R5"));
          m_x = {ref_rd(ea), ref_rd(ea1)};
        end else begin
          q.push_back(mk(m_sp, 1'b1, a3[7:0], a3, m_sp, 1'b0, "R7"));
          q.push_back(mk(m_sp - 16'd1, 1'b1, a3[15:8], a3, m_sp - 16'd1, 1'b0, "R7"));
          m_sp = m_sp - 16'd2;
          m_pc = opnd;
        end
      end
      default: begin
        q.push_back(mk(a1, 1'b0, 8'h00, a1, m_sp, 1'b0, "R9"));
        m_ill = 1'b1;
        m_pc  = a1;
      end
    endcase
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic cmp_all(input exp_t e);
    chk(e.we ? e.tag : "R10", "mem_we", {15'd0, mem_we}, {15'd0, e.we});
    chk(e.tag, "mem_addr", mem_addr, e.addr);
    if (e.we) chk(e.tag, "mem_wdata", {8'd0, mem_wdata}, {8'd0, e.wd});
    chk(e.tag, "pc", pc_o, e.pc);
    chk(e.tag, "x", x_o, e.x);
    chk(e.tag, "sp", sp_o, e.sp);
    chk(e.tag, "done", {15'd0, done_o}, {15'd0, e.done});
    chk(e.ill ? "R9" : e.tag, "illegal", {15'd0, illegal_o}, {15'd0, e.ill});
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      rel = 0;
      q.delete();
      m_pc = START; m_x = 16'h0; m_sp = 16'h0; m_ill = 1'b0; m_halt = 1'b0;
      cmp_all(mk(START, 1'b0, 8'h00, START, 16'h0, 1'b0, "R1"));
    end else begin
      rel++;
      if (rel <= 1) begin
        cmp_all(mk(START, 1'b0, 8'h00, START, 16'h0, 1'b0, "R1"));
      end else begin
        if (q.size() == 0) step();
        e = q.pop_front();
        if (e.we) ref_mem[int'(e.addr)] = e.wd;
        cmp_all(e);
      end
    end
  end

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    env_mem[int'(a)] = d;
    ref_mem[int'(a)] = d;
  endtask

  task automatic put3(input logic [15:0] a, input logic [7:0] o,
                      input logic [15:0] v);
    put(a, o);
    put(a + 16'd1, v[15:8]);
    put(a + 16'd2, v[7:0]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog R8: actual still running, expected halted");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R6 R4 R3 R5 R9 R7 program with wrap corner cases
    put3(16'hC000, 8'h8E, 16'hDFFF);
    put3(16'hC003, 8'hCE, 16'hC100);
    put (16'hC006, 8'h08);
    put3(16'hC007, 8'hFE, 16'hD000);
    put (16'hC00A, 8'h55);
    put3(16'hC00B, 8'hBD, 16'hC100);
    put3(16'hC100, 8'hFE, 16'hDFFE);
    put3(16'hC103, 8'hCE, 16'hFFFF);
    put (16'hC106, 8'h08);
    put3(16'hC107, 8'hFE, 16'hFFFF);
    put3(16'hC10A, 8'h8E, 16'h0000);
    put3(16'hC10D, 8'hBD, 16'hC200);
    put3(16'hC200, 8'hFE, 16'hFFFF);
    put (16'hC203, 8'h3F);
    put (16'hD000, 8'h12);
    put (16'hD001, 8'h34);
    put (16'hFFFF, 8'hAB);
    put (16'h0000, 8'hCD);

    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (120) @(negedge clk);
    // reset again, rerun partially, then reset mid-instruction
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (27) @(negedge clk);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (120) @(negedge clk);
    #2;
    finish_run();
  end

endmodule